// File: doc/BRIEF.md
# Programmable Stereo Sample Delay with Change Mute

This block delays a stream of stereo sample pairs by a whole number of sample periods. Each frame arrives as a left word and a right word with a one-cycle valid strobe. The same frame leaves the block a programmable number of frames later. A 6-bit delay code selects the length. The words are copied bit for bit, so the block can carry payloads that are not audio.

Some events make the buffer contents unusable: a change of the delay code, and reset. After either one, the output is forced to zero for exactly the newly selected number of frames. This way no stale or half-written samples reach the output. A bypass control sends each input frame straight to the output instead. Samples are stored in an inferred synchronous RAM that is addressed as a ring.

Top module: `stereo_delay_line`

## Requirements
- R1: The delay is D = 65 + 2048·c[0] + 1024·c[1] + 512·c[2] + 256·c[3] + 128·c[4] + 64·c[5] frames, where c is `delay_code`. In the bit weighting, the lowest-numbered bit carries the largest weight. Once muting has ended, the output registered for input frame j is input frame j−D, and both channels use the same D.
- R2: Code 0 gives the shortest delay of 65 frames, and code 63 gives the longest delay of 4097 frames.
- R3: Reset is synchronous and active high. The delay code present during reset sets D. The first D frames after reset produce all-zero outputs.
- R4: The code is compared with the previous frame's code at every valid frame. On a mismatch, that frame and the following D_new−1 frames produce zero outputs. After that, data is delayed by D_new.
- R5: Both 24-bit words are delivered unmodified. This holds for all-ones, all-zero, top-bit-only and mixed patterns.
- R6: `bypass` is sampled at each valid frame. Its level applies from the next valid frame onward. While it applies, the output is that frame's own input, and it is never muted.
- R7: Bypass does not reload or halt the mute count. Mute frames that pass during bypass are consumed.
- R8: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. The output words hold their value when no frame arrives. Cycles without `in_valid` advance neither the delay nor the mute count.
- R9: While reset is asserted, and until the first frame after reset, `out_valid` is 0 and both output words are 0.
- R10: A code change that is undone before the next valid frame is never seen and causes no mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input frame strobe |
| in_left | input | 24 | Left input word |
| in_right | input | 24 | Right input word |
| delay_code | input | 6 | Delay selection code |
| bypass | input | 1 | Route input directly to output |
| out_valid | output | 1 | Output frame strobe |
| out_left | output | 24 | Left output word |
| out_right | output | 24 | Right output word |

## Verification
The assertions check the following on every cycle:
- The strobe follows the input one cycle later.
- The output holds on idle cycles.
- The output is zero after any muted or code-changing frame.
- Bypass returns the previous input.
- The mute count steps down by exactly one per frame and never exceeds the longest delay.

Only the bench's scenarios can show the following:
- That the delayed data is the right frame from thousands of frames earlier, for every one of the 64 codes.
- That the mute window has exactly D frames.
- That muting ends at the right frame after bypass is turned off partway through a mute.

// File: rtl/sd_pkg.sv
package sd_pkg;

    localparam int unsigned SD_SAMPLE_W = 24;

    typedef logic [SD_SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    // Delay for a code: bit i carries weight 2^(ulog2 + cw-1-i), plus a fixed base.
    function automatic int unsigned sd_delay_of(input int unsigned code,
                                                input int unsigned cw,
                                                input int unsigned ulog2,
                                                input int unsigned base);
        int unsigned rev;
        rev = 0;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(cw) && code[i]) begin
                rev = rev | (32'd1 << (cw - 1 - i));
            end
        end
        return base + (rev << ulog2);
    endfunction

    function automatic int unsigned sd_max_delay(input int unsigned cw,
                                                 input int unsigned ulog2,
                                                 input int unsigned base);
        return sd_delay_of((32'd1 << cw) - 1, cw, ulog2, base);
    endfunction

endpackage

// File: rtl/sd_delay_decode.sv
module sd_delay_decode #(
    parameter int unsigned CODE_W     = 6,
    parameter int unsigned UNIT_LOG2  = 6,
    parameter int unsigned BASE_DELAY = 65,
    parameter int unsigned CNT_W      = 13
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  delay
);

    logic [CNT_W-1:0] term [CODE_W];

    // Reversed weighting: the lowest-numbered code bit has the largest weight.
    for (genvar g = 0; g < CODE_W; g++) begin : g_weight
        localparam int unsigned WEIGHT = 1 << (UNIT_LOG2 + CODE_W - 1 - g);
        assign term[g] = code[g] ? CNT_W'(WEIGHT) : '0;
    end

    always_comb begin
        delay = CNT_W'(BASE_DELAY);
        for (int i = 0; i < int'(CODE_W); i++) begin
            delay = delay + term[i];
        end
    end

endmodule

// File: rtl/sd_mute_ctrl.sv
module sd_mute_ctrl #(
    parameter int unsigned CODE_W = 6,
    parameter int unsigned CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  delay,
    input  logic              bypass_in,
    output logic              code_chg,
    output logic              mute_now,
    output logic              byp_now,
    output logic [CNT_W-1:0]  cnt_q
);

    logic [CODE_W-1:0] code_q;

    // The code seen at the previous frame; a mismatch at a frame is a change.
    assign code_chg = in_valid && (code != code_q);
    assign mute_now = code_chg || (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= code;
            cnt_q   <= delay;
            byp_now <= 1'b0;
        end else if (in_valid) begin
            code_q  <= code;
            byp_now <= bypass_in;
            if (code_chg) begin
                // This frame is the first muted frame of the new window.
                cnt_q <= delay - CNT_W'(1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sd_ring_store.sv
module sd_ring_store
    import sd_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  stereo_t          wdata,
    input  logic [CNT_W-1:0] delay,
    output stereo_t          rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    stereo_t           mem [DEPTH];
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] back;
    logic [ADDR_W-1:0] raddr;

    // The RAM supplies D-1 frames of delay and the output register adds the last
    // one. A back-step equal to DEPTH therefore wraps to the write slot itself,
    // which the read-first port returns before it is overwritten.
    assign back  = ADDR_W'(delay - CNT_W'(1));
    assign raddr = wptr - back;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            wptr  <= '0;
        end else if (wr_en) begin
            rdata <= mem[raddr];
            wptr  <= wptr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/stereo_delay_line.sv
module stereo_delay_line
    import sd_pkg::*;
#(
    parameter int unsigned CODE_W     = 6,
    parameter int unsigned UNIT_LOG2  = 6,
    parameter int unsigned BASE_DELAY = 65
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [SD_SAMPLE_W-1:0] in_left,
    input  logic [SD_SAMPLE_W-1:0] in_right,
    input  logic [CODE_W-1:0]      delay_code,
    input  logic                   bypass,
    output logic                   out_valid,
    output logic [SD_SAMPLE_W-1:0] out_left,
    output logic [SD_SAMPLE_W-1:0] out_right
);

    localparam int unsigned MAX_DELAY = sd_max_delay(CODE_W, UNIT_LOG2, BASE_DELAY);
    localparam int unsigned ADDR_W    = $clog2(MAX_DELAY - 1);
    localparam int unsigned CNT_W     = $clog2(MAX_DELAY + 1);

    stereo_t          in_frame;
    stereo_t          rd_frame;
    stereo_t          out_q;
    logic [CNT_W-1:0] delay;
    logic [CNT_W-1:0] mute_cnt;
    logic             code_chg;
    logic             mute_now;
    logic             byp_now;

    assign in_frame = '{left: in_left, right: in_right};

    sd_delay_decode #(
        .CODE_W    (CODE_W),
        .UNIT_LOG2 (UNIT_LOG2),
        .BASE_DELAY(BASE_DELAY),
        .CNT_W     (CNT_W)
    ) decode_i (
        .code (delay_code),
        .delay(delay)
    );

    sd_mute_ctrl #(
        .CODE_W(CODE_W),
        .CNT_W (CNT_W)
    ) mute_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .code     (delay_code),
        .delay    (delay),
        .bypass_in(bypass),
        .code_chg (code_chg),
        .mute_now (mute_now),
        .byp_now  (byp_now),
        .cnt_q    (mute_cnt)
    );

    sd_ring_store #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) ring_i (
        .clk  (clk),
        .rst  (rst),
        .wr_en(in_valid),
        .wdata(in_frame),
        .delay(delay),
        .rdata(rd_frame)
    );

    // rd_frame still holds the word read at the previous frame, which is the
    // one D frames back from the frame arriving now.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (byp_now) begin
                    out_q <= in_frame;
                end else if (mute_now) begin
                    out_q <= '0;
                end else begin
                    out_q <= rd_frame;
                end
            end
        end
    end

    assign out_left  = out_q.left;
    assign out_right = out_q.right;

endmodule

// File: rtl/stereo_delay_line_chk.sv
module stereo_delay_line_chk #(
    parameter int unsigned SW        = 24,
    parameter int unsigned CNT_W     = 13,
    parameter int unsigned MAX_DELAY = 4097
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [SW-1:0]    in_left,
    input logic [SW-1:0]    in_right,
    input logic             out_valid,
    input logic [SW-1:0]    out_left,
    input logic [SW-1:0]    out_right,
    input logic             code_chg,
    input logic             mute_now,
    input logic             byp_now,
    input logic [CNT_W-1:0] mute_cnt
);

    // R8
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_left) && $stable(out_right) && $stable(mute_cnt)));

    // R3
    muted_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mute_now && !byp_now) |=> (out_left == '0 && out_right == '0));

    // R4
    change_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_chg && !byp_now) |=> (out_left == '0 && out_right == '0));

    // R6
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && byp_now) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

    // R7
    mute_step_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !code_chg && mute_cnt != '0) |=> (mute_cnt == $past(mute_cnt) - 1'b1));

    // R2
    mute_bound_chk: assert property (@(posedge clk) disable iff (rst)
        mute_cnt <= CNT_W'(MAX_DELAY));

endmodule

bind stereo_delay_line stereo_delay_line_chk #(
    .SW       (sd_pkg::SD_SAMPLE_W),
    .CNT_W    (CNT_W),
    .MAX_DELAY(MAX_DELAY)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_left  (in_left),
    .in_right (in_right),
    .out_valid(out_valid),
    .out_left (out_left),
    .out_right(out_right),
    .code_chg (code_chg),
    .mute_now (mute_now),
    .byp_now  (byp_now),
    .mute_cnt (mute_cnt)
);

// File: tb/stereo_delay_line_tb_top.sv
`timescale 1ns/1ps
module stereo_delay_line_tb_top;

    localparam int HN = 4160;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic [5:0]  delay_code = '0;
    logic        bypass = 1'b0;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // bench model of the requirements
    logic [47:0] hist [HN];
    int          fidx;
    logic [5:0]  m_code;
    int          m_cnt;
    bit          m_byp;
    logic [47:0] last_out;

    always #4 clk = ~clk;

    stereo_delay_line dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .delay_code(delay_code),
        .bypass    (bypass),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    function automatic int ref_delay(input logic [5:0] c);
        return 65 + 2048 * int'(c[0]) + 1024 * int'(c[1]) + 512 * int'(c[2])
                   + 256 * int'(c[3]) + 128 * int'(c[4]) + 64 * int'(c[5]);
    endfunction

    function automatic logic [23:0] pat(input int k, input bit right);
        case (k % 4)
            0:       return right ? 24'h000001 : 24'hFFFFFF;
            1:       return right ? 24'h800000 : 24'h000000;
            default: return {k[11:0], ~k[11:0]} ^ (right ? 24'h5A5A5A : 24'h0);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [48:0] act,
                         input logic [48:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [5:0] code);
        rst = 1'b1;
        in_valid = 1'b0;
        delay_code = code;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R9",
              {out_valid, out_left, out_right}, 49'd0);
        rst = 1'b0;
        fidx = 0;
        m_code = code;
        m_cnt = ref_delay(code);
        m_byp = 0;
        last_out = '0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R9",
              {out_valid, out_left, out_right}, 49'd0);
    endtask

    task automatic idle(input logic [5:0] code);
        in_valid = 1'b0;
        delay_code = code;
        @(negedge clk);
        check(out_valid == 1'b0 && {out_left, out_right} == last_out, "R8",
              {out_valid, out_left, out_right}, {1'b0, last_out});
    endtask

    task automatic do_frame(input logic [5:0] code, input bit byp,
                            input string mtag, input string dtag);
        logic [23:0] l;
        logic [23:0] r;
        logic [47:0] exp;
        int          d;
        bit          reload;
        bit          mute;
        string       tag;
        l = pat(fidx, 0);
        r = pat(fidx, 1);
        in_valid = 1'b1;
        in_left = l;
        in_right = r;
        delay_code = code;
        bypass = byp;
        d = ref_delay(code);
        reload = (code != m_code);
        mute = reload || (m_cnt != 0);
        if (m_byp) begin
            exp = {l, r};
            tag = "R6";
        end else if (mute) begin
            exp = '0;
            tag = mtag;
        end else begin
            exp = hist[(fidx - d) % HN];
            tag = dtag;
        end
        hist[fidx % HN] = {l, r};
        fidx++;
        if (reload) m_cnt = d - 1;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        m_code = code;
        m_byp = byp;
        last_out = exp;
        @(negedge clk);
        check(out_valid == 1'b1 && {out_left, out_right} == exp, tag,
              {out_valid, out_left, out_right}, {1'b1, exp});
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        // R3 R9: reset with the shortest delay, then mute window and data (R1, R5)
        do_reset(6'd0);
        for (int i = 0; i < 70; i++) do_frame(6'd0, 1'b0, "R3", "R5");

        // R8: idle cycles neither advance the delay nor disturb the output
        idle(6'd0);
        idle(6'd0);
        for (int i = 0; i < 4; i++) do_frame(6'd0, 1'b0, "R8", "R8");

        // R10: code toggled during idle and restored before the next frame
        idle(6'd5);
        idle(6'd0);
        for (int i = 0; i < 3; i++) do_frame(6'd0, 1'b0, "R10", "R10");

        // R1 R2 R4: every code, each entered by a change, mute window then data
        for (int c = 1; c <= 64; c++) begin
            logic [5:0] code;
            code = 6'(c % 64);
            for (int i = 0; i < ref_delay(code) + 4; i++) begin
                if (code == 6'd0 || code == 6'd63) do_frame(code, 1'b0, "R2", "R2");
                else do_frame(code, 1'b0, "R4", "R1");
            end
        end

        // R6 R7: bypass starts with a code change and ends inside the mute window
        do_frame(6'd1, 1'b1, "R4", "R1");
        for (int i = 0; i < 20; i++) do_frame(6'd1, 1'b1, "R7", "R7");
        do_frame(6'd1, 1'b0, "R7", "R7");
        for (int i = 0; i < 2100; i++) do_frame(6'd1, 1'b0, "R7", "R7");

        // R3 R8: reset mid-stream with code 5 (delay 2625), idle gap inside the mute
        do_reset(6'd5);
        for (int i = 0; i < 1000; i++) do_frame(6'd5, 1'b0, "R3", "R1");
        idle(6'd5);
        idle(6'd5);
        for (int i = 0; i < 1630; i++) do_frame(6'd5, 1'b0, "R3", "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule